// File: doc/BRIEF.md
# Framebuffer Fill and Swap Controller

This block sits between a host register port and a pair of video framebuffers. The host programs a word count and a start word address, then writes a fill value. The block then writes that value into consecutive words of whichever framebuffer is not on display, one word per clock. Addresses advance only within a 256-word page. When the fill ends, the start register holds the address that follows the last word written, so the next fill can continue from that point without a new start write.

The block also owns the front-buffer select. A host write to the swap register takes effect in the next cycle when vertical blanking is active or the display mode field is zero. Otherwise the new value waits as a pending swap, and the next rising edge of vblank applies it. Host writes that arrive while a fill runs are held off by a stall signal until the fill ends.

The fill sequencer has two states. IDLE moves to RUN on START, which is an accepted write to the data register. RUN stays in RUN on STEP while more than one word remains. RUN returns to IDLE on LAST, in the cycle that writes the final word.

Top module: `fbfill_top`

## Requirements
- R1: After reset, busy, reg_stall and fb_we are low, front_sel is 0, fill_start is 0, the length and mode fields are 0 and no swap is pending.
- R2: A write to word offset 8 stores the write data and, from the next cycle, writes it on fb_wdata for length+1 consecutive cycles with fb_we and busy high. The first word goes to the current start address. A length of 0 writes exactly one word.
- R3: Each fill step adds 1 to bits [7:0] of the address only. Bits [15:8] stay unchanged, so 0x12FF is followed by 0x1200.
- R4: In the cycle after the last word of a fill, fill_start holds the address one step past the last word written, using the same page wrap.
- R5: Every fill word targets the buffer not on display: fb_sel equals the inverse of front_sel at the time the fill starts, and stays constant for the whole fill.
- R6: The fill length is bits [7:0] of word offset 4 and is written only through the low byte lane (reg_be[0]). A write to offset 4 that enables only the high lane leaves the length unchanged.
- R7: A write to word offset 10 with reg_be[0] set takes bit 0 as the new front select. The new value appears on front_sel in the next cycle when vblank is high or the mode field is 0, and any pending swap is cancelled.
- R8: With vblank low and a nonzero mode, a swap write only records a pending value. The next rising edge of vblank applies it one cycle later. A pending value cancelled by an immediate swap is never applied.
- R9: While busy is high, a register write is not accepted and reg_stall is high. The write takes effect once the host holds it until busy falls. The length and mode fields do not change during a fill.
- R10: The display mode field is bits [1:0] of word offset 0 and is written through the low byte lane. Only a zero mode lets a swap outside blanking apply at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write request, held until reg_stall is low |
| reg_be | input | 2 | Byte lane enables, bit 0 is bits [7:0] |
| reg_addr | input | 4 | Byte offset of the register word (even) |
| reg_wdata | input | 16 | Register write data |
| reg_stall | output | 1 | Write request is being held off by a running fill |
| vblank | input | 1 | Vertical blanking active |
| fb_we | output | 1 | Framebuffer word write strobe |
| fb_sel | output | 1 | Framebuffer targeted by the fill |
| fb_addr | output | 16 | Framebuffer word address |
| fb_wdata | output | 16 | Framebuffer write data |
| busy | output | 1 | Fill in progress |
| front_sel | output | 1 | Framebuffer currently on display |
| fill_start | output | 16 | Current fill start register |

## Verification
The assertions take for granted that the host keeps a stalled write steady until it is accepted, and that register addresses are even word offsets. They also take for granted that vblank stays low long enough between blanking intervals for a rise to be seen. The stimulus drives inputs only on falling edges and holds every write until it samples reg_stall low. It raises vblank only in separate, later cycles after a swap write, so a swap write and a vblank rise never fall in the same clock.

// File: rtl/fbfill_pkg.sv
package fbfill_pkg;

    typedef enum logic [0:0] {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_t;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 4'h0;
    localparam logic [REG_AW-1:0] OFS_LEN   = 4'h4;
    localparam logic [REG_AW-1:0] OFS_START = 4'h6;
    localparam logic [REG_AW-1:0] OFS_DATA  = 4'h8;
    localparam logic [REG_AW-1:0] OFS_SWAP  = 4'hA;

endpackage

// File: rtl/fbfill_regs.sv
module fbfill_regs
    import fbfill_pkg::*;
#(
    parameter int DW     = 16,
    parameter int LW     = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW/8-1:0]   wr_be,
    input  logic [DW-1:0]     wr_data,
    input  logic              vblank,
    input  logic              upd_en,
    input  logic [DW-1:0]     upd_addr,
    output logic [LW-1:0]     len_q,
    output logic [DW-1:0]     start_q,
    output logic [DW-1:0]     data_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              front_q,
    output logic              fill_go
);
    localparam int NLANE = DW / 8;

    logic vblank_d;
    logic pend_q;
    logic pend_val_q;
    logic swap_wr;
    logic vb_rise;
    logic swap_now;

    assign fill_go  = wr_en && (wr_addr == OFS_DATA);
    assign swap_wr  = wr_en && (wr_addr == OFS_SWAP) && wr_be[0];
    assign vb_rise  = vblank && !vblank_d;
    assign swap_now = vblank || (mode_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            len_q  <= '0;
            data_q <= '0;
        end else begin
            if (wr_en && (wr_addr == OFS_CTRL) && wr_be[0])
                mode_q <= wr_data[MODE_W-1:0];
            if (wr_en && (wr_addr == OFS_LEN) && wr_be[0])
                len_q <= wr_data[LW-1:0];
            if (fill_go)
                data_q <= wr_data;
        end
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_start_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                start_q[g*8 +: 8] <= '0;
            else if (upd_en)
                start_q[g*8 +: 8] <= upd_addr[g*8 +: 8];
            else if (wr_en && (wr_addr == OFS_START) && wr_be[g])
                start_q[g*8 +: 8] <= wr_data[g*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vblank_d   <= 1'b0;
            front_q    <= 1'b0;
            pend_q     <= 1'b0;
            pend_val_q <= 1'b0;
        end else begin
            vblank_d <= vblank;
            if (swap_wr) begin
                if (swap_now) begin
                    front_q <= wr_data[0];
                    pend_q  <= 1'b0;
                end else begin
                    pend_q     <= 1'b1;
                    pend_val_q <= wr_data[0];
                end
            end else if (vb_rise && pend_q) begin
                front_q <= pend_val_q;
                pend_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fbfill_seq.sv
module fbfill_seq
    import fbfill_pkg::*;
#(
    parameter int DW = 16,
    parameter int LW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] start_addr,
    input  logic [LW-1:0] len,
    input  logic          target,
    output logic          fb_we,
    output logic          fb_sel,
    output logic [DW-1:0] fb_addr,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] next_addr
);
    localparam int CW = LW + 1;

    fill_state_t   state_q, state_d;
    logic [DW-1:0] addr_q;
    logic [CW-1:0] left_q;
    logic          sel_q;
    logic          last;

    assign next_addr = {addr_q[DW-1:PW], addr_q[PW-1:0] + PW'(1)};
    assign last      = (left_q == CW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE: if (go)   state_d = FILL_RUN;
            FILL_RUN:  if (last) state_d = FILL_IDLE;
            default:             state_d = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FILL_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            sel_q  <= 1'b0;
        end else if (state_q == FILL_IDLE && go) begin
            addr_q <= start_addr;
            left_q <= CW'(len) + CW'(1);
            sel_q  <= target;
        end else if (state_q == FILL_RUN) begin
            addr_q <= next_addr;
            left_q <= left_q - CW'(1);
        end
    end

    always_comb begin
        fb_we   = (state_q == FILL_RUN);
        busy    = (state_q == FILL_RUN);
        done    = (state_q == FILL_RUN) && last;
        fb_sel  = sel_q;
        fb_addr = addr_q;
    end

endmodule

// File: rtl/fbfill_top.sv
module fbfill_top
    import fbfill_pkg::*;
#(
    parameter int DW     = 16,
    parameter int LW     = 8,
    parameter int PW     = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DW/8-1:0]   reg_be,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              reg_stall,
    input  logic              vblank,
    output logic              fb_we,
    output logic              fb_sel,
    output logic [DW-1:0]     fb_addr,
    output logic [DW-1:0]     fb_wdata,
    output logic              busy,
    output logic              front_sel,
    output logic [DW-1:0]     fill_start
);
    logic              wr_en;
    logic              fill_go;
    logic              done;
    logic [DW-1:0]     next_addr;
    logic [LW-1:0]     len_q;
    logic [DW-1:0]     data_q;
    logic [MODE_W-1:0] mode_q;

    assign wr_en     = reg_we && !busy;
    assign reg_stall = reg_we && busy;
    assign fb_wdata  = data_q;

    fbfill_regs #(.DW(DW), .LW(LW), .MODE_W(MODE_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (reg_addr),
        .wr_be    (reg_be),
        .wr_data  (reg_wdata),
        .vblank   (vblank),
        .upd_en   (done),
        .upd_addr (next_addr),
        .len_q    (len_q),
        .start_q  (fill_start),
        .data_q   (data_q),
        .mode_q   (mode_q),
        .front_q  (front_sel),
        .fill_go  (fill_go)
    );

    fbfill_seq #(.DW(DW), .LW(LW), .PW(PW)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (fill_go),
        .start_addr (fill_start),
        .len        (len_q),
        .target     (!front_sel),
        .fb_we      (fb_we),
        .fb_sel     (fb_sel),
        .fb_addr    (fb_addr),
        .busy       (busy),
        .done       (done),
        .next_addr  (next_addr)
    );

endmodule

// File: rtl/fbfill_chk.sv
module fbfill_chk #(
    parameter int DW     = 16,
    parameter int LW     = 8,
    parameter int PW     = 8,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fb_we,
    input logic              fb_sel,
    input logic [DW-1:0]     fb_addr,
    input logic              busy,
    input logic              front_sel,
    input logic              vblank,
    input logic [DW-1:0]     fill_start,
    input logic [LW-1:0]     len_q,
    input logic [MODE_W-1:0] mode_q
);
    // R3
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && $past(fb_we)) |->
            ((fb_addr[DW-1:PW] == $past(fb_addr[DW-1:PW])) &&
             (fb_addr[PW-1:0] == PW'($past(fb_addr[PW-1:0]) + PW'(1)))));

    // R2
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (fb_addr == $past(fill_start)));

    // R4
    final_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |->
            ((fill_start[DW-1:PW] == $past(fb_addr[DW-1:PW])) &&
             (fill_start[PW-1:0] == PW'($past(fb_addr[PW-1:0]) + PW'(1)))));

    // R5
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && $past(fb_we)) |-> $stable(fb_sel));

    // R7
    swap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (front_sel != $past(front_sel)) |-> ($past(vblank) || ($past(mode_q) == '0)));

    // R9
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ($stable(len_q) && $stable(mode_q)));

endmodule

bind fbfill_top fbfill_chk #(.DW(DW), .LW(LW), .PW(PW), .MODE_W(MODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fb_we      (fb_we),
    .fb_sel     (fb_sel),
    .fb_addr    (fb_addr),
    .busy       (busy),
    .front_sel  (front_sel),
    .vblank     (vblank),
    .fill_start (fill_start),
    .len_q      (len_q),
    .mode_q     (mode_q)
);

// File: tb/fbfill_top_tb_top.sv
module fbfill_top_tb_top;

    localparam logic [3:0] A_CTRL  = 4'h0;
    localparam logic [3:0] A_LEN   = 4'h4;
    localparam logic [3:0] A_START = 4'h6;
    localparam logic [3:0] A_DATA  = 4'h8;
    localparam logic [3:0] A_SWAP  = 4'hA;

    typedef struct packed {
        logic        sel;
        logic [15:0] addr;
        logic [15:0] data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic        vblank = 1'b0;
    logic        reg_stall, fb_we, fb_sel, busy, front_sel;
    logic [15:0] fb_addr, fb_wdata, fill_start;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    exp_front = 1'b0;
    bit    saw_stall = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    fbfill_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_be(reg_be),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_stall(reg_stall),
        .vblank(vblank), .fb_we(fb_we), .fb_sel(fb_sel), .fb_addr(fb_addr),
        .fb_wdata(fb_wdata), .busy(busy), .front_sel(front_sel),
        .fill_start(fill_start)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: pops expected words as the design writes them
    always @(negedge clk) begin
        if (rst_n && fb_we) begin
            if (sb_q.size() == 0) begin
                check("R2 unexpected word", {15'd0, fb_sel, fb_addr}, 32'hFFFFFFFF);
            end else begin
                item_t e;
                e = sb_q.pop_front();
                check("R2/R3/R5 fill word", {fb_sel, fb_addr, fb_wdata[14:0]},
                      {e.sel, e.addr, e.data[14:0]});
            end
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        #1;
        while (reg_stall) begin
            saw_stall = 1'b1;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        reg_we = 1'b0; reg_be = 2'b00;
    endtask

    task automatic push_fill(input logic [15:0] st, input int len, input logic [15:0] d);
        for (int i = 0; i <= len; i++) begin
            item_t it;
            it.sel  = ~exp_front;
            it.addr = {st[15:8], 8'(st[7:0] + i)};
            it.data = d;
            sb_q.push_back(it);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_fill(input string req, input logic [15:0] st, input int len, input logic [15:0] d);
        reg_write(A_START, 2'b11, st);
        reg_write(A_LEN, 2'b01, 16'(len));
        push_fill(st, len, d);
        reg_write(A_DATA, 2'b11, d);
        wait_idle();
        check({req, " final start"}, fill_start, {st[15:8], 8'(st[7:0] + len + 1)});
        check({req, " all words"}, sb_q.size(), 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 busy", busy, 0);
        check("R1 fb_we", fb_we, 0);
        check("R1 front", front_sel, 0);
        check("R1 start", fill_start, 0);
        check("R1 stall", reg_stall, 0);

        // R2 R4 R5 basic fill into back buffer 1
        run_fill("R2 R4", 16'h1234, 3, 16'hAAAA);
        // R3 page wrap
        run_fill("R3 R4", 16'h12FE, 3, 16'h5A5A);
        // R2 length zero writes one word
        run_fill("R2 len0", 16'h0800, 0, 16'h0001);

        // R6 high-lane write to length is ignored
        reg_write(A_LEN, 2'b01, 16'h0002);
        reg_write(A_LEN, 2'b10, 16'h0700);
        reg_write(A_START, 2'b11, 16'h2000);
        push_fill(16'h2000, 2, 16'h1111);
        reg_write(A_DATA, 2'b11, 16'h1111);
        wait_idle();
        check("R6 length kept", sb_q.size(), 0);
        check("R6 final start", fill_start, 16'h2003);

        // R7 immediate swap with mode zero
        reg_write(A_SWAP, 2'b01, 16'h0001);
        exp_front = 1'b1;
        check("R7 immediate", front_sel, 1);
        run_fill("R5 other buffer", 16'h3000, 1, 16'hBEEF);

        // R10 R8 pending swap outside blanking
        reg_write(A_CTRL, 2'b01, 16'h0001);
        reg_write(A_CTRL, 2'b10, 16'h0000);
        reg_write(A_SWAP, 2'b01, 16'h0000);
        repeat (2) @(negedge clk);
        check("R10 R8 held", front_sel, 1);
        vblank = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 applied on rise", front_sel, 0);
        // R7 immediate during blanking with nonzero mode
        reg_write(A_SWAP, 2'b01, 16'h0001);
        check("R7 during vblank", front_sel, 1);
        vblank = 1'b0;
        repeat (2) @(negedge clk);

        // R8 cancel: pending 0, then immediate 1 with mode zero
        reg_write(A_SWAP, 2'b01, 16'h0000);
        reg_write(A_CTRL, 2'b01, 16'h0000);
        reg_write(A_SWAP, 2'b01, 16'h0001);
        reg_write(A_CTRL, 2'b01, 16'h0002);
        vblank = 1'b1;
        repeat (3) @(negedge clk);
        vblank = 1'b0;
        check("R8 cancelled", front_sel, 1);
        exp_front = 1'b1;

        // R9 write during a fill is stalled then applied
        reg_write(A_START, 2'b11, 16'h40F0);
        reg_write(A_LEN, 2'b01, 16'd20);
        push_fill(16'h40F0, 20, 16'hC3C3);
        reg_write(A_DATA, 2'b11, 16'hC3C3);
        check("R9 busy", busy, 1);
        saw_stall = 1'b0;
        reg_write(A_START, 2'b11, 16'h5000);
        check("R9 stall seen", saw_stall, 1);
        check("R9 write applied", fill_start, 16'h5000);
        check("R9 words", sb_q.size(), 0);

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule